// File: doc/BRIEF.md
# Framed Serial Voice Sample Port

This block is a full-duplex bit-serial port for voice samples. It sits between a codec core, which produces and consumes samples as parallel words, and a serial line. On that line one word per direction travels in each 8 kHz frame, and a sync strobe marks the frame. The block's clock is the bit clock itself. Transmit bits change on its rising edge and receive bits are sampled on its falling edge. The transmit and receive directions have independent sync inputs. In each direction, the first bit period after the strobe's rising edge carries the most significant bit of the word.

A format input selects one of three word lengths: 8-bit companded, 14-bit linear two's complement, or 4-bit ADPCM codes. The word length is captured when each word starts. The core offers a transmit word with a one-cycle load strobe, and the port holds it until the next transmit sync. If no word was offered since the last frame, the port sends the idle code for the selected format. A received word is handed to the core right-justified, together with a one-cycle valid pulse. Whenever the transmit driver is not sending a word it is released, and power-down releases it at once.

Top module: `sport_codec_port`

## Requirements
- R1: While reset is asserted and after it is released, `tx_en_o` is 0, `rx_valid_o` is 0 and `rx_word_o` is 0, and they stay so until a sync arrives.
- R2: The format code on `fmt_i` selects the word length: 2'b00 gives 8 bits, 2'b01 gives 14 bits, and 2'b10 or 2'b11 gives 4 bits. Words are taken from and delivered on the low bits of the parallel buses.
- R3: A rising edge of `tx_sync_i` seen at a rising clock edge starts a transmit word. Its MSB is on `tx_sd_o` from that edge, and each later rising edge presents the next lower bit. `tx_en_o` is high for exactly the word length in cycles, and after that `tx_en_o` is 0 and `tx_sd_o` is 1 until the next sync.
- R4: A `tx_load_i` pulse stores `tx_word_i`, and the next transmit sync sends the stored word. A load in the same cycle as the sync takes effect in the following frame.
- R5: If no load occurred since the previous transmit sync, the port sends the idle code: 8'hD5 for companded with `law_i`=0, 8'hFF for companded with `law_i`=1, and all zeros for linear and ADPCM.
- R6: While `pwr_on_i` is 0, `tx_en_o` is 0 in the same cycle and any word in progress is abandoned. A transmit sync during power-down is ignored and leaves a stored word pending.
- R7: A rising edge of `rx_sync_i` seen at a falling clock edge captures `rx_sd_i` as the MSB. Each later falling edge captures the next bit.
- R8: `rx_valid_o` is high for one cycle, after the falling edge that captured the LSB. `rx_word_o` then holds the word right-justified with zero upper bits, and it stays unchanged until the next word completes.
- R9: A sync held high for several cycles starts only one word.
- R10: A change of `fmt_i` after a word has started does not change that word's length in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_i | input | 1 | 0 puts the transmit side into power-down |
| fmt_i | input | 2 | Word format select |
| law_i | input | 1 | Idle code choice for companded words |
| tx_sync_i | input | 1 | Transmit frame strobe |
| tx_load_i | input | 1 | Stores `tx_word_i` for the next frame |
| tx_word_i | input | 14 | Parallel transmit word, right-justified |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_en_o | output | 1 | Transmit driver enable; 0 means released |
| rx_sync_i | input | 1 | Receive frame strobe |
| rx_sd_i | input | 1 | Serial receive data |
| rx_word_o | output | 14 | Last received word, right-justified |
| rx_valid_o | output | 1 | One-cycle pulse when a word is complete |

## Verification
The bench sends words in every format with patterns chosen to expose faults: alternating bits, full-scale positive and negative linear values, and values whose MSB and LSB differ. These catch bit-order reversal, off-by-one word lengths and lost upper bits. Frames with no load tell idle-code substitution apart from a repeat of stale data, and a load in the same cycle as the sync tells apart the two possible orderings of hold and latch. A widened sync pulse, a format change during a word, and power-down both for a whole frame and in the middle of a word show whether framing restarts by mistake and whether a pending word survives.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    FMT_CMP  = 2'd0,
    FMT_LIN  = 2'd1,
    FMT_ADP  = 2'd2,
    FMT_ADP2 = 2'd3
  } fmt_e;
endpackage

// File: rtl/sport_wlen.sv
module sport_wlen
  import sport_pkg::*;
#(
  parameter int LIN_W = 14,
  parameter int CMP_W = 8,
  parameter int ADP_W = 4,
  localparam int CW = $clog2(LIN_W)
) (
  input  fmt_e          fmt,
  output logic [CW-1:0] lenm1
);
  always_comb begin
    case (fmt)
      FMT_CMP: lenm1 = CW'(CMP_W - 1);
      FMT_LIN: lenm1 = CW'(LIN_W - 1);
      default: lenm1 = CW'(ADP_W - 1);
    endcase
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
#(
  parameter int LIN_W = 14,
  parameter int CMP_W = 8,
  parameter int ADP_W = 4,
  parameter logic [CMP_W-1:0] IDLE_ALAW = 8'hD5,
  localparam int CW = $clog2(LIN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  fmt_e             fmt,
  input  logic             law,
  input  logic             sync,
  input  logic             load,
  input  logic [LIN_W-1:0] word,
  output logic             sd_o,
  output logic             en_o
);
  localparam logic [CW-1:0] TOPBIT = CW'(LIN_W - 1);

  logic             sync_q;
  logic             act_q, act_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [LIN_W-1:0] sh_q, sh_n;
  logic [LIN_W-1:0] hold_q, hold_n;
  logic             pend_q, pend_n;
  logic [CW-1:0]    lenm1;
  logic [LIN_W-1:0] idle_w, src_w;
  logic             start;

  sport_wlen #(.LIN_W(LIN_W), .CMP_W(CMP_W), .ADP_W(ADP_W)) u_len (
    .fmt  (fmt),
    .lenm1(lenm1)
  );

  always_comb begin
    case (fmt)
      FMT_CMP: idle_w = law ? {{(LIN_W-CMP_W){1'b0}}, {CMP_W{1'b1}}}
                            : {{(LIN_W-CMP_W){1'b0}}, IDLE_ALAW};
      default: idle_w = '0;
    endcase
  end

  assign start = sync & ~sync_q & pwr_on;
  assign src_w = pend_q ? hold_q : idle_w;

  always_comb begin
    act_n  = act_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    hold_n = hold_q;
    pend_n = pend_q;
    if (load) begin
      hold_n = word;
      pend_n = 1'b1;
    end
    if (!pwr_on) begin
      act_n = 1'b0;
    end else if (start) begin
      sh_n  = src_w << (TOPBIT - lenm1);
      cnt_n = lenm1;
      act_n = 1'b1;
      if (!load) pend_n = 1'b0;
    end else if (act_q) begin
      sh_n = sh_q << 1;
      if (cnt_q == '0) act_n = 1'b0;
      else             cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync;
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      hold_q <= hold_n;
      pend_q <= pend_n;
    end
  end

  assign sd_o = act_q ? sh_q[LIN_W-1] : 1'b1;
  assign en_o = act_q & pwr_on;

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> act_q);
  assert_word_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q == '0 && !start) |=> !en_o);
  assert_load_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pend_q);
  assert_pdn_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !act_q);
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int LIN_W = 14,
  parameter int CMP_W = 8,
  parameter int ADP_W = 4,
  localparam int CW = $clog2(LIN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic             sync,
  input  logic             sd,
  output logic [LIN_W-1:0] word_o,
  output logic             valid_o
);
  logic             sync_q;
  logic             act_q, act_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [LIN_W-1:0] sh_q, sh_n;
  logic [LIN_W-1:0] word_n;
  logic             valid_n;
  logic [CW-1:0]    lenm1;
  logic             start;

  sport_wlen #(.LIN_W(LIN_W), .CMP_W(CMP_W), .ADP_W(ADP_W)) u_len (
    .fmt  (fmt),
    .lenm1(lenm1)
  );

  assign start = sync & ~sync_q;

  always_comb begin
    act_n   = act_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    word_n  = word_o;
    valid_n = 1'b0;
    if (start) begin
      sh_n  = {{(LIN_W-1){1'b0}}, sd};
      cnt_n = lenm1;
      act_n = 1'b1;
    end else if (act_q) begin
      sh_n  = {sh_q[LIN_W-2:0], sd};
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        act_n   = 1'b0;
        word_n  = sh_n;
        valid_n = 1'b1;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      sync_q  <= sync;
      act_q   <= act_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      word_o  <= word_n;
      valid_o <= valid_n;
    end
  end

  assert_valid_single_R8: assert property (@(negedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_word_steady_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(word_o));
  assert_last_bit_R7: assert property (@(negedge clk) disable iff (!rst_n)
    (act_q && cnt_q == CW'(1) && !start) |=> valid_o);
endmodule

// File: rtl/sport_codec_port.sv
module sport_codec_port
  import sport_pkg::*;
#(
  parameter int LIN_W = 14,
  parameter int CMP_W = 8,
  parameter int ADP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on_i,
  input  logic [1:0]       fmt_i,
  input  logic             law_i,
  input  logic             tx_sync_i,
  input  logic             tx_load_i,
  input  logic [LIN_W-1:0] tx_word_i,
  output logic             tx_sd_o,
  output logic             tx_en_o,
  input  logic             rx_sync_i,
  input  logic             rx_sd_i,
  output logic [LIN_W-1:0] rx_word_o,
  output logic             rx_valid_o
);
  fmt_e fmt;
  assign fmt = fmt_e'(fmt_i);

  sport_tx #(.LIN_W(LIN_W), .CMP_W(CMP_W), .ADP_W(ADP_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .pwr_on(pwr_on_i),
    .fmt   (fmt),
    .law   (law_i),
    .sync  (tx_sync_i),
    .load  (tx_load_i),
    .word  (tx_word_i),
    .sd_o  (tx_sd_o),
    .en_o  (tx_en_o)
  );

  sport_rx #(.LIN_W(LIN_W), .CMP_W(CMP_W), .ADP_W(ADP_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .fmt    (fmt),
    .sync   (rx_sync_i),
    .sd     (rx_sd_i),
    .word_o (rx_word_o),
    .valid_o(rx_valid_o)
  );

  assert_released_in_pdn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on_i |-> !tx_en_o);
endmodule

// File: tb/sport_codec_port_bench.sv
`timescale 1ns/1ps
module sport_codec_port_bench;
  localparam int FRAME = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on = 1'b1;
  logic [1:0]  fmt = 2'd0;
  logic        law = 1'b0;
  logic        tx_sync = 1'b0;
  logic        tx_load = 1'b0;
  logic [13:0] tx_word = '0;
  logic        tx_sd, tx_en;
  logic        rx_sync = 1'b0;
  logic        rx_sd = 1'b1;
  logic [13:0] rx_word;
  logic        rx_valid;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  bit          txq[$];
  logic [13:0] rxq[$];
  bit          m_pend = 0;
  logic [13:0] m_hold = '0;

  always #2 clk = ~clk;

  sport_codec_port u_sport_codec_port (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on), .fmt_i(fmt), .law_i(law),
    .tx_sync_i(tx_sync), .tx_load_i(tx_load), .tx_word_i(tx_word),
    .tx_sd_o(tx_sd), .tx_en_o(tx_en),
    .rx_sync_i(rx_sync), .rx_sd_i(rx_sd),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid)
  );

  function automatic int wlen(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 14 : 4;
  endfunction

  function automatic logic [13:0] idle_code(input logic [1:0] m, input logic lw);
    if (m == 2'd0) return lw ? 14'h00FF : 14'h00D5;
    return 14'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [13:0] act, input logic [13:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops expected transmit bits and received words
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      if (tx_en) begin
        if (txq.size() == 0) check(0, "R3 enable beyond word", 14'(tx_en), 14'h0);
        else begin
          bit e;
          e = txq.pop_front();
          check(tx_sd === e, "R3/R5 transmit bit", 14'(tx_sd), 14'(e));
        end
      end
      if (rx_valid) begin
        if (rxq.size() == 0) check(0, "R8 unexpected valid", 14'(rx_valid), 14'h0);
        else begin
          logic [13:0] e;
          e = rxq.pop_front();
          check(rx_word === e, "R7/R8 received word", rx_word, e);
        end
      end
    end
  end

  task automatic preload(input logic [13:0] w);
    @(posedge clk); #1;
    tx_load = 1'b1; tx_word = w;
    @(posedge clk); #1;
    tx_load = 1'b0;
    m_pend = 1; m_hold = w;
  endtask

  // pd_at: 0 none, -1 powered down all frame, k>0 power-down from cycle k
  task automatic frame(input logic [1:0] m, input logic lw, input bit ld,
                       input logic [13:0] ldw, input logic [13:0] rxw,
                       input int swidth, input bit midchg, input int pd_at);
    int len;
    logic [13:0] txw, rxm;
    len = wlen(m);
    rxm = rxw & 14'((1 << len) - 1);
    if (pd_at >= 0) begin
      txw = m_pend ? m_hold : idle_code(m, lw);
      for (int i = len - 1; i >= 0; i--) txq.push_back(txw[i]);
      m_pend = ld;
      if (ld) m_hold = ldw;
    end
    rxq.push_back(rxm);
    @(posedge clk); #1;
    fmt = m; law = lw; tx_sync = 1'b1; rx_sync = 1'b1;
    rx_sd = rxm[len-1]; tx_load = ld; tx_word = ldw;
    if (pd_at < 0) pwr_on = 1'b0;
    for (int c = 1; c < FRAME; c++) begin
      @(posedge clk); #1;
      tx_load = 1'b0;
      if (c >= swidth) begin tx_sync = 1'b0; rx_sync = 1'b0; end
      rx_sd = (c < len) ? rxm[len-1-c] : 1'b1;
      if (midchg && c == 2) fmt = (m == 2'd1) ? 2'd2 : 2'd1;
      if (pd_at > 0 && c == pd_at) begin
        pwr_on = 1'b0;
        #2;
        check(tx_en === 1'b0, "R6 released at once", 14'(tx_en), 14'h0);
        txq.delete();
      end else if (c == FRAME - 1) begin
        #2;
        check(tx_en === 1'b0 && tx_sd === 1'b1 && txq.size() == 0,
              "R3 word length and idle level", {tx_en, tx_sd, 12'(txq.size())}, 14'h1000);
      end
    end
    pwr_on = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: got hang expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check(tx_en === 1'b0 && rx_valid === 1'b0 && rx_word === 14'h0,
          "R1 reset state", {tx_en, rx_valid, rx_word[11:0]}, 14'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check(tx_en === 1'b0 && rx_valid === 1'b0 && rx_word === 14'h0,
          "R1 after release", {tx_en, rx_valid, rx_word[11:0]}, 14'h0);

    // R5 idle codes, R2 word lengths, R7 receive
    frame(2'd0, 1'b0, 0, '0, 14'h00A3, 1, 0, 0);
    frame(2'd0, 1'b1, 0, '0, 14'h0081, 1, 0, 0);
    // R4 stored word, companded
    preload(14'h005A);
    frame(2'd0, 1'b0, 0, '0, 14'h003C, 1, 0, 0);
    // linear full scale patterns, R2
    preload(14'h1FFF);
    frame(2'd1, 1'b0, 0, '0, 14'h2000, 1, 0, 0);
    frame(2'd1, 1'b0, 0, '0, 14'h0000, 1, 0, 0);
    // ADPCM, both codes
    preload(14'h0009);
    frame(2'd2, 1'b0, 0, '0, 14'h0006, 1, 0, 0);
    frame(2'd3, 1'b1, 0, '0, 14'h3FF9, 1, 0, 0);
    // R4 load in the sync cycle applies to the next frame
    frame(2'd0, 1'b0, 1, 14'h0011, 14'h00F0, 1, 0, 0);
    frame(2'd0, 1'b0, 0, '0, 14'h000F, 1, 0, 0);
    // R9 wide sync
    preload(14'h2AAA);
    frame(2'd1, 1'b0, 0, '0, 14'h1555, 3, 0, 0);
    // R10 format change after start
    preload(14'h3001);
    frame(2'd1, 1'b0, 0, '0, 14'h2003, 1, 1, 0);
    frame(2'd2, 1'b0, 0, '0, 14'h000A, 1, 1, 0);
    // R6 power-down for a whole frame keeps the stored word pending
    preload(14'h00C3);
    frame(2'd0, 1'b0, 0, '0, 14'h0055, 1, 0, -1);
    frame(2'd0, 1'b0, 0, '0, 14'h00AA, 1, 0, 0);
    // R6 power-down in the middle of a word, then idle follows
    preload(14'h0096);
    frame(2'd0, 1'b1, 0, '0, 14'h0001, 1, 0, 4);
    frame(2'd0, 1'b1, 0, '0, 14'h0080, 1, 0, 0);

    repeat (4) @(posedge clk);
    #3;
    check(rxq.size() == 0 && txq.size() == 0, "R8 all words delivered",
          14'(rxq.size()), 14'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule